// File: doc/BRIEF.md
# Audio Master Clock Generator

This block turns one fast, fixed system clock into an audio master clock running at a chosen multiple of the sample rate (nFs). The master clock drives an external converter. Rates that divide the system clock evenly are produced by a plain half-period counter and have an exact 50% duty cycle. The 44.1 kHz family and the other uneven ratios are produced by a modulo accumulator. Its average frequency is exact, and each edge lands within one system-clock period of its ideal time.

The block also divides its own master clock down to the sample rate. This gives a one-cycle word strobe and a square phase reference for an external loop filter. An external VCO sends a smoothed copy of the master clock back in. That copy is synchronised, divided by the same ratio and presented as a second phase reference, so the two references can be compared at equal frequency. A select input chooses which of the two divided clocks times the word strobe.

A new rate or ratio request is held and applied only on a sample-period boundary. A boundary is a falling edge of the master clock, so no shortened pulse ever appears on the output.

Top module: `audio_mclk_gen`

## Requirements
- R1: While reset is asserted, and at the first sample after it is released, mclkOut, wordStrobe, pdSysOut and pdVcoOut are all low.
- R2: rateSel codes are 0=32 kHz, 1=44.1 kHz, 2=48 kHz, 3=88.2 kHz, 4=96 kHz and 5=192 kHz. ratioSel codes are 0=128, 1=192, 2=256, 3=384 and 4=512. Let H = SRC_HZ/(2·Fs·ratio) be the half period in system cycles. When H is an integer, every high phase and every low phase of mclkOut lasts exactly H cycles.
- R3: When H is not an integer, every high or low phase lasts floor(H) or ceil(H) cycles. In addition, any 10 consecutive sample periods span floor or ceil of 10·SRC_HZ/Fs cycles, so the average rate is exact (44.1 kHz at 256·Fs gives 11145 or 11146).
- R4: With wordSrcSel=0, wordStrobe pulses high for one cycle once every ratio master-clock periods. It rises in the cycle right after a falling edge of mclkOut, so mclkOut is low while the strobe is high.
- R5: A request whose code is out of range, or whose 2·Fs·ratio exceeds SRC_HZ, is ignored. The clock already running continues unchanged.
- R6: A valid request is applied at the first sample-period boundary after it has been registered. A request registered on the boundary edge itself is applied one period later. After a change, no phase of mclkOut is shorter than the shorter half period of the old and new settings.
- R7: pdSysOut is a square wave at Fs. It is low for the first ratio/2 master periods of each sample period and high for the rest. It changes only on a falling edge of mclkOut.
- R8: vcoClkIn is synchronised, and its rising edges are divided by the active ratio. pdVcoOut is then high for the second half of each group of ratio edges, and it is low whenever a returned-clock boundary strobe is issued.
- R9: With wordSrcSel=1, wordStrobe marks every ratio rising edges of vcoClkIn instead of the internal boundary. Setting it back to 0 returns the strobe to the internal timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock (SRC_HZ) |
| rstN | input | 1 | Asynchronous active-low reset |
| rateSel | input | 3 | Sample-rate request code |
| ratioSel | input | 3 | Master-clock multiple request code |
| wordSrcSel | input | 1 | 0: word strobe from generated clock, 1: from returned clock |
| vcoClkIn | input | 1 | Smoothed master clock returned by external VCO |
| mclkOut | output | 1 | Generated nFs master clock |
| wordStrobe | output | 1 | One-cycle pulse per sample period |
| pdSysOut | output | 1 | Fs phase reference from generated clock |
| pdVcoOut | output | 1 | Fs phase reference from returned clock |

## Verification
A rate request and a sample-period boundary can land on the same clock edge. In that case the pending setting is still the old one when the boundary tests it, and the change has to slip by exactly one period. The bench counts cycles from a word strobe and places the request either one cycle before the boundary edge or exactly on it. It then checks that the following strobe intervals are the new length at once in the first case, and one old-length period later in the second. Each master-clock phase around the switch is also measured to confirm that no runt phase appears.

// File: rtl/mclkgen_pkg.sv
package mclkgen_pkg;

  localparam int STEP_W    = 32;
  localparam int HALF_W    = 16;
  localparam int RATIO_W   = 10;
  localparam int SEL_W     = 3;
  localparam int NUM_RATE  = 6;
  localparam int NUM_RATIO = 5;

  // Active clock setting, resolved from a request code pair
  typedef struct packed {
    logic               intMode;
    logic [HALF_W-1:0]  halfCnt;
    logic [STEP_W-1:0]  step;
    logic [RATIO_W-1:0] ratio;
  } mclkCfg_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;
  } ctrlStb_t;

  function automatic longint unsigned rateHz(input int unsigned code);
    case (code)
      0:       rateHz = 32000;
      1:       rateHz = 44100;
      2:       rateHz = 48000;
      3:       rateHz = 88200;
      4:       rateHz = 96000;
      default: rateHz = 192000;
    endcase
  endfunction

  function automatic longint unsigned ratioMul(input int unsigned code);
    case (code)
      0:       ratioMul = 128;
      1:       ratioMul = 192;
      2:       ratioMul = 256;
      3:       ratioMul = 384;
      default: ratioMul = 512;
    endcase
  endfunction

  // Toggle rate: two edges per master period
  function automatic longint unsigned stepOf(input int unsigned r, input int unsigned q);
    stepOf = 2 * rateHz(r) * ratioMul(q);
  endfunction

  function automatic logic cfgOk(input longint unsigned srcHz,
                                 input int unsigned r, input int unsigned q);
    cfgOk = (r < NUM_RATE) && (q < NUM_RATIO) && (stepOf(r, q) <= srcHz);
  endfunction

  function automatic mclkCfg_t makeCfg(input longint unsigned srcHz,
                                       input int unsigned r, input int unsigned q);
    mclkCfg_t c;
    longint unsigned s;
    s         = stepOf(r, q);
    c.step    = STEP_W'(s);
    c.halfCnt = HALF_W'(srcHz / s);
    c.intMode = ((srcHz % s) == 0);
    c.ratio   = RATIO_W'(ratioMul(q));
    makeCfg   = c;
  endfunction

endpackage

// File: rtl/mclkgen_ctrl.sv
module mclkgen_ctrl
  import mclkgen_pkg::*;
#(
  parameter int unsigned SRC_HZ    = 49152000,
  parameter int unsigned DEF_RATE  = 2,
  parameter int unsigned DEF_RATIO = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [SEL_W-1:0] rateSel,
  input  logic [SEL_W-1:0] ratioSel,
  input  logic             fsBoundary,
  output mclkCfg_t         activeCfg,
  output ctrlStb_t         stb
);

  localparam int       NUM_CFG = NUM_RATE * NUM_RATIO;
  localparam int       IDX_W   = $clog2(NUM_CFG);
  localparam mclkCfg_t DEF_CFG = makeCfg(SRC_HZ, DEF_RATE, DEF_RATIO);

  mclkCfg_t       cfgTab [NUM_CFG];
  logic           okTab  [NUM_CFG];
  mclkCfg_t       pendCfg;
  mclkCfg_t       reqCfg;
  logic           rateIn, ratioIn, reqOk;
  logic [IDX_W-1:0] lookIdx;

  // Elaboration-time table of every code pair: no runtime division
  for (genvar r = 0; r < NUM_RATE; r++) begin : g_rate
    for (genvar q = 0; q < NUM_RATIO; q++) begin : g_ratio
      assign cfgTab[r*NUM_RATIO+q] = makeCfg(SRC_HZ, r, q);
      assign okTab[r*NUM_RATIO+q]  = cfgOk(SRC_HZ, r, q);
    end
  end

  assign rateIn  = (rateSel  < SEL_W'(NUM_RATE));
  assign ratioIn = (ratioSel < SEL_W'(NUM_RATIO));
  assign lookIdx = (rateIn && ratioIn)
                   ? IDX_W'(IDX_W'(rateSel) * IDX_W'(NUM_RATIO) + IDX_W'(ratioSel))
                   : '0;
  assign reqCfg  = cfgTab[lookIdx];
  assign reqOk   = rateIn && ratioIn && okTab[lookIdx];

  assign stb = '{load: fsBoundary && (pendCfg != activeCfg)};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendCfg   <= DEF_CFG;
      activeCfg <= DEF_CFG;
    end else begin
      if (reqOk)    pendCfg   <= reqCfg;
      if (stb.load) activeCfg <= pendCfg;
    end
  end

endmodule

// File: rtl/mclkgen_dp.sv
module mclkgen_dp
  import mclkgen_pkg::*;
#(
  parameter int unsigned SRC_HZ      = 49152000,
  parameter int          SYNC_STAGES = 2
) (
  input  logic     clk,
  input  logic     rstN,
  input  mclkCfg_t cfg,
  input  ctrlStb_t stb,
  input  logic     vcoClkIn,
  input  logic     wordSrcSel,
  output logic     fsBoundary,
  output logic     mclkOut,
  output logic     wordStrobe,
  output logic     pdSysOut,
  output logic     pdVcoOut
);

  localparam logic [STEP_W:0]    SRC_EXT  = (STEP_W+1)'(SRC_HZ);
  localparam logic [HALF_W-1:0]  HALF_ONE = 1;
  localparam logic [RATIO_W-1:0] R_ONE    = 1;

  logic [STEP_W-1:0]  acc;
  logic [STEP_W:0]    accSum;
  logic [HALF_W-1:0]  halfCtr;
  logic [RATIO_W-1:0] cycCnt, vcoCnt, ratioLast, ratioMid;
  logic               fracHit, intHit, toggle, mclkQ, pdSysQ, pdVcoQ;
  logic [SYNC_STAGES-1:0] vcoSync;
  logic               vcoPrev, vcoRise, vcoBoundary, strobeQ;

  // Edge scheduler: fractional accumulator or integer half-period counter
  assign accSum  = {1'b0, acc} + {1'b0, cfg.step};
  assign fracHit = (accSum >= SRC_EXT);
  assign intHit  = (halfCtr >= (cfg.halfCnt - HALF_ONE));
  assign toggle  = cfg.intMode ? intHit : fracHit;

  assign ratioLast  = cfg.ratio - R_ONE;
  assign ratioMid   = (cfg.ratio >> 1) - R_ONE;
  assign fsBoundary = toggle && mclkQ && (cycCnt >= ratioLast);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      acc     <= '0;
      halfCtr <= '0;
      mclkQ   <= 1'b0;
      cycCnt  <= '0;
      pdSysQ  <= 1'b0;
    end else if (stb.load) begin
      // Boundary edge: master clock falls here, new setting starts clean
      acc     <= '0;
      halfCtr <= '0;
      mclkQ   <= 1'b0;
      cycCnt  <= '0;
      pdSysQ  <= 1'b0;
    end else begin
      acc     <= fracHit ? STEP_W'(accSum - SRC_EXT) : accSum[STEP_W-1:0];
      halfCtr <= intHit ? '0 : halfCtr + HALF_ONE;
      if (toggle) begin
        mclkQ <= ~mclkQ;
        if (mclkQ) begin
          if (cycCnt >= ratioLast) begin
            cycCnt <= '0;
            pdSysQ <= 1'b0;
          end else begin
            cycCnt <= cycCnt + R_ONE;
            if (cycCnt == ratioMid) pdSysQ <= 1'b1;
          end
        end
      end
    end
  end

  // Returned clock: synchroniser chain
  for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) vcoSync[0] <= 1'b0;
        else       vcoSync[0] <= vcoClkIn;
    end else begin : g_next
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) vcoSync[i] <= 1'b0;
        else       vcoSync[i] <= vcoSync[i-1];
    end
  end

  assign vcoRise     = vcoSync[SYNC_STAGES-1] && !vcoPrev;
  assign vcoBoundary = vcoRise && (vcoCnt >= ratioLast);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vcoPrev <= 1'b0;
      vcoCnt  <= '0;
      pdVcoQ  <= 1'b0;
      strobeQ <= 1'b0;
    end else begin
      vcoPrev <= vcoSync[SYNC_STAGES-1];
      if (vcoRise) begin
        if (vcoCnt >= ratioLast) begin
          vcoCnt <= '0;
          pdVcoQ <= 1'b0;
        end else begin
          vcoCnt <= vcoCnt + R_ONE;
          if (vcoCnt == ratioMid) pdVcoQ <= 1'b1;
        end
      end
      strobeQ <= wordSrcSel ? vcoBoundary : fsBoundary;
    end
  end

  assign mclkOut    = mclkQ;
  assign pdSysOut   = pdSysQ;
  assign pdVcoOut   = pdVcoQ;
  assign wordStrobe = strobeQ;

endmodule

// File: rtl/audio_mclk_gen.sv
module audio_mclk_gen
  import mclkgen_pkg::*;
#(
  parameter int unsigned SRC_HZ    = 49152000,
  parameter int unsigned DEF_RATE  = 2,
  parameter int unsigned DEF_RATIO = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [SEL_W-1:0] rateSel,
  input  logic [SEL_W-1:0] ratioSel,
  input  logic             wordSrcSel,
  input  logic             vcoClkIn,
  output logic             mclkOut,
  output logic             wordStrobe,
  output logic             pdSysOut,
  output logic             pdVcoOut
);

  mclkCfg_t activeCfg;
  ctrlStb_t stb;
  logic     fsBoundary;

  mclkgen_ctrl #(
    .SRC_HZ(SRC_HZ), .DEF_RATE(DEF_RATE), .DEF_RATIO(DEF_RATIO)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .rateSel(rateSel), .ratioSel(ratioSel),
    .fsBoundary(fsBoundary), .activeCfg(activeCfg), .stb(stb)
  );

  mclkgen_dp #(
    .SRC_HZ(SRC_HZ), .SYNC_STAGES(2)
  ) u_dp (
    .clk(clk), .rstN(rstN), .cfg(activeCfg), .stb(stb),
    .vcoClkIn(vcoClkIn), .wordSrcSel(wordSrcSel), .fsBoundary(fsBoundary),
    .mclkOut(mclkOut), .wordStrobe(wordStrobe),
    .pdSysOut(pdSysOut), .pdVcoOut(pdVcoOut)
  );

endmodule

// File: rtl/audio_mclk_gen_chk.sv
module audio_mclk_gen_chk (
  input logic clk,
  input logic rstN,
  input logic wordSrcSel,
  input logic mclkOut,
  input logic wordStrobe,
  input logic pdSysOut,
  input logic pdVcoOut
);

  // R4: internally timed strobe follows a falling master edge
  a_r4_mclk_low_at_strobe: assert property (@(posedge clk) disable iff (!rstN)
    (wordStrobe && !$past(wordSrcSel)) |-> !mclkOut);

  // R7: phase reference is low at the start of each sample period
  a_r7_pdsys_low_at_strobe: assert property (@(posedge clk) disable iff (!rstN)
    (wordStrobe && !$past(wordSrcSel)) |-> !pdSysOut);

  // R7: phase reference moves only on a falling master edge
  a_r7_pdsys_on_fall: assert property (@(posedge clk) disable iff (!rstN)
    (pdSysOut != $past(pdSysOut)) |-> ($past(mclkOut) && !mclkOut));

  // R8: returned-clock reference is low when its boundary strobe fires
  a_r8_pdvco_low_at_strobe: assert property (@(posedge clk) disable iff (!rstN)
    (wordStrobe && $past(wordSrcSel)) |-> !pdVcoOut);

endmodule

bind audio_mclk_gen audio_mclk_gen_chk u_chk (
  .clk(clk), .rstN(rstN), .wordSrcSel(wordSrcSel), .mclkOut(mclkOut),
  .wordStrobe(wordStrobe), .pdSysOut(pdSysOut), .pdVcoOut(pdVcoOut)
);

// File: tb/audio_mclk_gen_tb.sv
module audio_mclk_gen_tb;

  logic       clk = 1'b0;
  logic       rstN;
  logic [2:0] rateSel, ratioSel;
  logic       wordSrcSel, vcoClkIn, vcoRun;
  logic       mclkOut, wordStrobe, pdSysOut, pdVcoOut;
  int         checks = 0;
  int         fails  = 0;
  bit         done   = 0;

  audio_mclk_gen u_dut (
    .clk(clk), .rstN(rstN), .rateSel(rateSel), .ratioSel(ratioSel),
    .wordSrcSel(wordSrcSel), .vcoClkIn(vcoClkIn), .mclkOut(mclkOut),
    .wordStrobe(wordStrobe), .pdSysOut(pdSysOut), .pdVcoOut(pdVcoOut)
  );

  always #4 clk = ~clk;

  // Returned clock: period of 6 system cycles when running
  initial begin
    vcoClkIn = 1'b0;
    forever begin
      repeat (3) @(negedge clk);
      if (vcoRun) vcoClkIn = ~vcoClkIn;
    end
  end

  // rate, ratio, interval lo/hi, phase lo/hi
  localparam int NVEC = 8;
  localparam int VEC [NVEC][6] = '{
    '{2, 2, 1024, 1024, 2, 2},
    '{0, 0, 1536, 1536, 6, 6},
    '{5, 0,  256,  256, 1, 1},
    '{1, 2, 1114, 1115, 2, 3},
    '{2, 1, 1024, 1024, 2, 3},
    '{4, 2,  512,  512, 1, 1},
    '{3, 0,  557,  558, 2, 3},
    '{0, 4, 1536, 1536, 1, 2}
  };

  task automatic checkRange(input string req, input int act, input int lo, input int hi);
    checks++;
    if (act < lo || act > hi) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  task automatic waitStrobe();
    do @(negedge clk); while (!wordStrobe);
  endtask

  task automatic setSel(input int r, input int q);
    rateSel  = 3'(r);
    ratioSel = 3'(q);
  endtask

  // From a strobe sample to the next: interval plus master phase extremes
  task automatic measure(output int iv, output int pMin, output int pMax);
    logic lvl;
    int   run;
    lvl = mclkOut; run = 1; iv = 0; pMin = 1 << 30; pMax = 0;
    do begin
      @(negedge clk);
      iv++;
      if (mclkOut == lvl) run++;
      else begin
        if (run < pMin) pMin = run;
        if (run > pMax) pMax = run;
        lvl = mclkOut; run = 1;
      end
    end while (!wordStrobe);
  endtask

  task automatic pdHigh(input bit useVco, output int w);
    do @(negedge clk); while ((useVco ? pdVcoOut : pdSysOut) != 1'b0);
    do @(negedge clk); while ((useVco ? pdVcoOut : pdSysOut) != 1'b1);
    w = 0;
    do begin @(negedge clk); w++; end while ((useVco ? pdVcoOut : pdSysOut) == 1'b1);
  endtask

  task automatic pdLow(output int w);
    do @(negedge clk); while (pdSysOut != 1'b1);
    do @(negedge clk); while (pdSysOut != 1'b0);
    w = 0;
    do begin @(negedge clk); w++; end while (pdSysOut == 1'b0);
  endtask

  initial begin
    repeat (190000) @(negedge clk);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finishRun();
  end

  initial begin
    int iv, pMin, pMax, sum, w;
    rstN = 1'b0; wordSrcSel = 1'b0; vcoRun = 1'b0;
    setSel(2, 2);
    repeat (5) @(negedge clk);
    checkRange("R1 mclk in reset", int'(mclkOut), 0, 0);
    rstN = 1'b1;
    @(negedge clk);
    checkRange("R1 mclk", int'(mclkOut), 0, 0);
    checkRange("R1 strobe", int'(wordStrobe), 0, 0);
    checkRange("R1 pdSys", int'(pdSysOut), 0, 0);
    checkRange("R1 pdVco", int'(pdVcoOut), 0, 0);

    // Table walk: R2 (integer), R3 (fractional), R4 (interval)
    for (int i = 0; i < NVEC; i++) begin
      setSel(VEC[i][0], VEC[i][1]);
      waitStrobe(); waitStrobe();
      measure(iv, pMin, pMax);
      checkRange("R4 strobe interval", iv, VEC[i][2], VEC[i][3]);
      checkRange((VEC[i][4] == VEC[i][5]) ? "R2 min phase" : "R3 min phase", pMin, VEC[i][4], VEC[i][5]);
      checkRange((VEC[i][4] == VEC[i][5]) ? "R2 max phase" : "R3 max phase", pMax, VEC[i][4], VEC[i][5]);
    end

    // R3: average rate exact over ten periods at 44.1 kHz x256
    setSel(1, 2);
    waitStrobe(); waitStrobe();
    sum = 0;
    for (int k = 0; k < 10; k++) begin
      measure(iv, pMin, pMax);
      sum += iv;
    end
    checkRange("R3 ten-period span", sum, 11145, 11146);

    // R5: unsupported requests leave 48 kHz x256 running
    setSel(2, 2);
    waitStrobe(); waitStrobe();
    setSel(5, 4); waitStrobe(); waitStrobe(); measure(iv, pMin, pMax);
    checkRange("R5 too fast 192k x512", iv, 1024, 1024);
    setSel(5, 2); waitStrobe(); waitStrobe(); measure(iv, pMin, pMax);
    checkRange("R5 too fast 192k x256", iv, 1024, 1024);
    setSel(6, 2); waitStrobe(); waitStrobe(); measure(iv, pMin, pMax);
    checkRange("R5 rate code 6", iv, 1024, 1024);
    setSel(2, 7); waitStrobe(); waitStrobe(); measure(iv, pMin, pMax);
    checkRange("R5 ratio code 7", iv, 1024, 1024);
    checkRange("R5 phase kept", pMin, 2, 2);

    // R6: request one cycle before the boundary edge applies at once
    setSel(2, 2);
    waitStrobe(); waitStrobe();
    waitStrobe();
    repeat (1022) @(negedge clk);
    setSel(0, 0);
    waitStrobe();
    measure(iv, pMin, pMax);
    checkRange("R6 early request interval", iv, 1536, 1536);
    checkRange("R6 no runt phase", pMin, 6, 6);

    // R6: request on the boundary edge slips one period
    setSel(2, 2);
    waitStrobe(); waitStrobe();
    waitStrobe();
    repeat (1023) @(negedge clk);
    setSel(0, 0);
    waitStrobe();
    measure(iv, pMin, pMax);
    checkRange("R6 late request old period", iv, 1024, 1024);
    checkRange("R6 late old phase", pMin, 2, 2);
    measure(iv, pMin, pMax);
    checkRange("R6 late request new period", iv, 1536, 1536);

    // R7: internal phase reference at 48 kHz x256
    setSel(2, 2);
    waitStrobe(); waitStrobe();
    pdHigh(1'b0, w);
    checkRange("R7 pdSys high width", w, 512, 512);
    pdLow(w);
    checkRange("R7 pdSys low width", w, 512, 512);

    // R8, R9: returned clock with period 6
    vcoRun = 1'b1;
    wordSrcSel = 1'b1;
    waitStrobe(); waitStrobe();
    measure(iv, pMin, pMax);
    checkRange("R9 returned-clock strobe interval", iv, 1536, 1536);
    pdHigh(1'b1, w);
    checkRange("R8 pdVco high width x256", w, 768, 768);

    setSel(2, 0);
    repeat (4000) @(negedge clk);
    waitStrobe();
    measure(iv, pMin, pMax);
    checkRange("R9 returned-clock interval x128", iv, 768, 768);
    pdHigh(1'b1, w);
    checkRange("R8 pdVco high width x128", w, 384, 384);

    wordSrcSel = 1'b0;
    waitStrobe(); waitStrobe();
    measure(iv, pMin, pMax);
    checkRange("R9 back to internal timing", iv, 1024, 1024);

    finishRun();
  end

endmodule